// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of an eight-input successive-approximation converter. A host writes an 8-bit control word with an active-low write strobe. On the strobe's rising edge the sequencer latches the channel, range and polarity selection, starts the track phase and, after an acquisition interval, runs a most-significant-bit-first binary search. Each search step drives a trial word to the converter's DAC and keeps or clears the bit under test according to a single comparator bit.

Acquisition is either timed internally for a fixed number of clocks or held open by the host until a second write. A new write aborts a conversion in flight. A power-down request in the control word waits for the end of the conversion it was written with. The active-low shutdown pin acts at once. The clock-source choice keeps its value across power-down requests. An active-low completion flag tells the host that the result register holds a fresh code.

Top module: `sar_seq_top`

## Requirements
- R1: After reset the completion flag `done_n` is high, `track` and `busy` are low, `clk_int` is 0 (external clock), `stby` and `full_pd` are low and `result` is 0.
- R2: A write with bit 5 of the control word at 0 raises `track` for exactly ACQ_CYC clocks, counted from the strobe's rising edge. `busy` then rises for the conversion, and `track` and `busy` are never both high.
- R3: A write with bit 5 at 1 holds `track` high with no time limit. A later write with bit 5 at 1 keeps tracking. A later write with bit 5 at 0 starts the conversion on its own rising edge, with no timed acquisition.
- R4: A conversion lasts RES_W clocks. It tests bits from RES_W-1 down to 0 through `dac_code` and keeps a bit when `cmp_in` is 1. On the final step the code is loaded into `result` and `done_n` falls.
- R5: Bits 2..0 of the accepted control word drive `chan_sel`, bit 3 drives `bip_sel` and bit 4 drives `rng_sel`.
- R6: `done_n` returns high on a falling edge of `rd_n` or on a write's rising edge. A read leaves `result` unchanged.
- R7: A write during a conversion abandons it, and the next result and completion follow the new write's timing and input.
- R8: Bits 7..6 of the control word set the clock choice: 00 selects external (`clk_int`=0) and 01 selects internal (`clk_int`=1). The codes 10 and 11 leave `clk_int` as it was.
- R9: Code 10 raises `stby` and code 11 raises `full_pd`, in both cases only at the end of the conversion started by that write. The next falling edge of `wr_n` clears both.
- R10: While `shdn_n` is low, `full_pd` is high, any conversion or acquisition stops, no completion is flagged and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Active-low write strobe, sampled on clk |
| rd_n | input | 1 | Active-low read strobe, sampled on clk |
| shdn_n | input | 1 | Active-low hardware shutdown |
| ctrl_byte | input | 8 | Control word, captured on the write strobe's rising edge |
| cmp_in | input | 1 | Comparator decision: input at or above the trial level |
| dac_code | output | RES_W | Trial word for the DAC |
| result | output | RES_W | Last completed conversion code |
| done_n | output | 1 | Active-low completion flag |
| track | output | 1 | Track/hold in track phase |
| busy | output | 1 | Conversion in progress |
| chan_sel | output | 3 | Selected input channel |
| rng_sel | output | 1 | Full-scale range select |
| bip_sel | output | 1 | Bipolar mode select |
| clk_int | output | 1 | Internal clock source selected |
| stby | output | 1 | Standby power-down active |
| full_pd | output | 1 | Full power-down active (software or pin) |

## Verification
The bench models an ideal comparator: `cmp_in` is high when the trial word is at or below a chosen code. A correct search therefore returns that code. The codes tried are zero, all ones, the midscale code and irregular patterns. The extremes show whether every bit is cleared or kept correctly. The midscale code separates an off-by-one pointer from a correct one, and the irregular codes expose swapped or stuck bits. Timing is checked one cycle before and one cycle after each expected edge, for timed acquisition, host-timed acquisition, an aborted conversion and a shutdown during a conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ACQ_TIMED,
      ST_ACQ_HOST,
      ST_CONV
   } seq_state_e;

   // control word: bit positions are decoded by the sequencer
   typedef struct packed {
      logic [1:0] pwr;      // 7:6 clock / power-down code
      logic       acq_host; // 5   host-timed acquisition
      logic       rng;      // 4   range
      logic       bip;      // 3   polarity
      logic [2:0] chan;     // 2:0 channel
   } ctrl_word_t;

endpackage

// File: rtl/sar_strobe_edges.sv
module sar_strobe_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_n,
   input  logic rd_n,
   output logic wr_rise,
   output logic wr_fall,
   output logic rd_fall
);
   logic wr_q, rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= 1'b1;
         rd_q <= 1'b1;
      end else begin
         wr_q <= wr_n;
         rd_q <= rd_n;
      end
   end

   assign wr_rise = wr_n & ~wr_q;
   assign wr_fall = ~wr_n & wr_q;
   assign rd_fall = ~rd_n & rd_q;
endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
   import sar_seq_pkg::*;
#(
   parameter int ACQ_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shdn_n,
   input  logic wr_rise,
   input  logic rd_fall,
   input  logic acq_host,
   input  logic conv_last,
   output logic conv_start,
   output logic conv_step,
   output logic conv_done,
   output logic track,
   output logic busy,
   output logic done_n
);
   localparam int CNT_W = $clog2(ACQ_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(ACQ_CYC - 1);

   generate
      if (ACQ_CYC < 1) begin : g_bad_acq
         $error("ACQ_CYC must be at least 1");
      end
   endgenerate

   seq_state_e       state;
   logic [CNT_W-1:0] acq_cnt;
   logic             acq_end, host_go;

   assign acq_end    = (state == ST_ACQ_TIMED) && (acq_cnt == CNT_END);
   assign host_go    = wr_rise && (state == ST_ACQ_HOST) && !acq_host;
   assign conv_start = shdn_n && (host_go || (!wr_rise && acq_end));
   assign conv_step  = shdn_n && !wr_rise && (state == ST_CONV);
   assign conv_done  = conv_step && conv_last;
   assign track      = (state == ST_ACQ_TIMED) || (state == ST_ACQ_HOST);
   assign busy       = (state == ST_CONV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         acq_cnt <= '0;
      end else if (!shdn_n) begin
         state   <= ST_IDLE;
         acq_cnt <= '0;
      end else if (wr_rise) begin
         acq_cnt <= '0;
         if (host_go)       state <= ST_CONV;
         else if (acq_host) state <= ST_ACQ_HOST;
         else               state <= ST_ACQ_TIMED;
      end else begin
         unique case (state)
            ST_ACQ_TIMED: begin
               if (acq_end) state <= ST_CONV;
               else         acq_cnt <= acq_cnt + 1'b1;
            end
            ST_CONV: if (conv_last) state <= ST_IDLE;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  done_n <= 1'b1;
      else if (conv_done)          done_n <= 1'b0;
      else if (wr_rise || rd_fall) done_n <= 1'b1;
   end

   AST_ACQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACQ_TIMED) |-> (acq_cnt <= CNT_END)); // R2
   AST_TRACK_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(track && busy)); // R2
   AST_DONE_FROM_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_n) |-> ($past(state) == ST_CONV)); // R4
   AST_SHDN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !shdn_n |=> (state == ST_IDLE)); // R10
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
   parameter int RES_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             step,
   input  logic             cmp_in,
   output logic             last,
   output logic [RES_W-1:0] trial,
   output logic [RES_W-1:0] result
);
   localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

   generate
      if (RES_W < 2) begin : g_bad_res
         $error("RES_W must be at least 2");
      end
   endgenerate

   logic [RES_W-1:0] ptr, nxt;

   // bit under test takes the comparator, the next lower bit becomes the trial
   generate
      for (genvar i = 0; i < RES_W; i++) begin : g_bit
         if (i == RES_W - 1) begin : g_top
            assign nxt[i] = ptr[i] ? cmp_in : trial[i];
         end else begin : g_low
            assign nxt[i] = ptr[i] ? cmp_in : (ptr[i+1] ? 1'b1 : trial[i]);
         end
      end
   endgenerate

   assign last = ptr[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= '0;
         trial  <= '0;
         result <= '0;
      end else if (start) begin
         ptr   <= TOP_BIT;
         trial <= TOP_BIT;
      end else if (step) begin
         ptr   <= ptr >> 1;
         trial <= nxt;
         if (ptr[0]) result <= nxt;
      end
   end

   AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ptr)); // R4
   AST_RESULT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> $past(step && ptr[0])); // R4
endmodule

// File: rtl/sar_mode_reg.sv
module sar_mode_reg (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_rise,
   input  logic       wr_fall,
   input  logic       conv_done,
   input  logic [1:0] pwr,
   input  logic       rng,
   input  logic       bip,
   input  logic [2:0] chan,
   output logic       clk_int,
   output logic       stby,
   output logic       full_sw,
   output logic       rng_sel,
   output logic       bip_sel,
   output logic [2:0] chan_sel
);
   logic pend, pend_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_int   <= 1'b0;
         stby      <= 1'b0;
         full_sw   <= 1'b0;
         pend      <= 1'b0;
         pend_full <= 1'b0;
         rng_sel   <= 1'b0;
         bip_sel   <= 1'b0;
         chan_sel  <= '0;
      end else begin
         if (wr_fall) begin
            stby    <= 1'b0;
            full_sw <= 1'b0;
         end
         if (wr_rise) begin
            chan_sel  <= chan;
            rng_sel   <= rng;
            bip_sel   <= bip;
            pend      <= pwr[1];
            pend_full <= pwr[0];
            if (!pwr[1]) clk_int <= pwr[0];
         end else if (conv_done && pend) begin
            stby    <= ~pend_full;
            full_sw <= pend_full;
            pend    <= 1'b0;
         end
      end
   end

   AST_PD_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(stby) || $rose(full_sw)) |-> $past(conv_done)); // R9
   AST_CLK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rise && pwr[1]) |=> $stable(clk_int)); // R8
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
   import sar_seq_pkg::*;
#(
   parameter int RES_W   = 12,
   parameter int ACQ_CYC = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_n,
   input  logic             rd_n,
   input  logic             shdn_n,
   input  logic [7:0]       ctrl_byte,
   input  logic             cmp_in,
   output logic [RES_W-1:0] dac_code,
   output logic [RES_W-1:0] result,
   output logic             done_n,
   output logic             track,
   output logic             busy,
   output logic [2:0]       chan_sel,
   output logic             rng_sel,
   output logic             bip_sel,
   output logic             clk_int,
   output logic             stby,
   output logic             full_pd
);
   ctrl_word_t cw;
   logic wr_rise_raw, wr_fall_raw, rd_fall;
   logic wr_rise, wr_fall;
   logic conv_start, conv_step, conv_done, conv_last, full_sw;

   assign cw = ctrl_byte;

   sar_strobe_edges u_edges (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_n    (wr_n),
      .rd_n    (rd_n),
      .wr_rise (wr_rise_raw),
      .wr_fall (wr_fall_raw),
      .rd_fall (rd_fall)
   );

   // the shutdown pin masks writes
   assign wr_rise = wr_rise_raw & shdn_n;
   assign wr_fall = wr_fall_raw & shdn_n;

   sar_seq_fsm #(.ACQ_CYC(ACQ_CYC)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .shdn_n     (shdn_n),
      .wr_rise    (wr_rise),
      .rd_fall    (rd_fall),
      .acq_host   (cw.acq_host),
      .conv_last  (conv_last),
      .conv_start (conv_start),
      .conv_step  (conv_step),
      .conv_done  (conv_done),
      .track      (track),
      .busy       (busy),
      .done_n     (done_n)
   );

   sar_approx #(.RES_W(RES_W)) u_approx (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (conv_start),
      .step   (conv_step),
      .cmp_in (cmp_in),
      .last   (conv_last),
      .trial  (dac_code),
      .result (result)
   );

   sar_mode_reg u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_rise   (wr_rise),
      .wr_fall   (wr_fall),
      .conv_done (conv_done),
      .pwr       (cw.pwr),
      .rng       (cw.rng),
      .bip       (cw.bip),
      .chan      (cw.chan),
      .clk_int   (clk_int),
      .stby      (stby),
      .full_sw   (full_sw),
      .rng_sel   (rng_sel),
      .bip_sel   (bip_sel),
      .chan_sel  (chan_sel)
   );

   assign full_pd = full_sw | ~shdn_n;

   AST_SHDN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      !shdn_n |-> full_pd); // R10
endmodule

// File: tb/sar_seq_top_test.sv
module sar_seq_top_test;
   localparam int RES_W = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_n = 1'b1;
   logic rd_n = 1'b1;
   logic shdn_n = 1'b1;
   logic [7:0] ctrl_byte = 8'h00;
   logic cmp_in;
   logic [RES_W-1:0] dac_code, result;
   logic done_n, track, busy, rng_sel, bip_sel, clk_int, stby, full_pd;
   logic [2:0] chan_sel;
   logic [RES_W-1:0] vin = '0;
   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   // ideal comparator: input at or above the trial level
   assign cmp_in = (dac_code <= vin);

   sar_seq_top uut (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .shdn_n(shdn_n),
      .ctrl_byte(ctrl_byte), .cmp_in(cmp_in), .dac_code(dac_code),
      .result(result), .done_n(done_n), .track(track), .busy(busy),
      .chan_sel(chan_sel), .rng_sel(rng_sel), .bip_sel(bip_sel),
      .clk_int(clk_int), .stby(stby), .full_pd(full_pd)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // returns on the negedge that releases the strobe; the rise is seen next posedge
   task automatic do_write(input logic [7:0] b);
      @(negedge clk);
      wr_n = 1'b0;
      ctrl_byte = b;
      @(negedge clk);
      wr_n = 1'b1;
   endtask

   task automatic conv_timed(input logic [7:0] b, input logic [RES_W-1:0] v);
      vin = v;
      do_write(b);
      step(1);
      chk("R2 track start", track, 1);
      chk("R5 chan", chan_sel, int'(b[2:0]));
      chk("R5 bip", bip_sel, int'(b[3]));
      chk("R5 rng", rng_sel, int'(b[4]));
      step(5);
      chk("R2 track last cycle", track, 1);
      chk("R2 busy before end", busy, 0);
      step(1);
      chk("R2 track ended", track, 0);
      chk("R2 busy started", busy, 1);
      step(11);
      chk("R4 done_n before end", done_n, 1);
      step(1);
      chk("R4 done_n fell", done_n, 0);
      chk("R4 result", int'(result), int'(v));
      chk("R4 busy cleared", busy, 0);
   endtask

   task automatic t_reset();
      chk("R1 done_n", done_n, 1);
      chk("R1 track", track, 0);
      chk("R1 busy", busy, 0);
      chk("R1 clk_int", clk_int, 0);
      chk("R1 stby", stby, 0);
      chk("R1 full_pd", full_pd, 0);
      chk("R1 result", int'(result), 0);
   endtask

   task automatic t_codes();
      conv_timed(8'h00, 12'h000);
      conv_timed(8'h1D, 12'hFFF);
      conv_timed(8'h0A, 12'h800);
      conv_timed(8'h13, 12'hA5C);
      conv_timed(8'h07, 12'h7FF);
      conv_timed(8'h1E, 12'h361);
   endtask

   task automatic t_read();
      conv_timed(8'h01, 12'h5A5);
      @(negedge clk) rd_n = 1'b0;
      @(negedge clk) rd_n = 1'b1;
      chk("R6 read clears done_n", done_n, 1);
      chk("R6 result kept", int'(result), 12'h5A5);
      conv_timed(8'h02, 12'h0F0);
      do_write(8'h02);
      step(1);
      chk("R6 write clears done_n", done_n, 1);
      step(18);
      chk("R6 next done", done_n, 0);
   endtask

   task automatic t_host_acq();
      vin = 12'h9C3;
      do_write(8'h26);
      step(30);
      chk("R3 still tracking", track, 1);
      chk("R3 no conversion", busy, 0);
      chk("R3 no done", done_n, 1);
      do_write(8'h26);
      step(5);
      chk("R3 restart tracks", track, 1);
      chk("R3 restart no conv", busy, 0);
      do_write(8'h06);
      step(1);
      chk("R3 conv on write", busy, 1);
      chk("R3 track ended", track, 0);
      step(11);
      chk("R3 done_n before end", done_n, 1);
      step(1);
      chk("R3 done_n fell", done_n, 0);
      chk("R3 result", int'(result), 12'h9C3);
   endtask

   task automatic t_abort();
      vin = 12'h123;
      do_write(8'h03);
      step(10);
      chk("R7 converting", busy, 1);
      vin = 12'hDB6;
      do_write(8'h03);
      step(1);
      chk("R7 back to tracking", track, 1);
      step(17);
      chk("R7 no early done", done_n, 1);
      step(1);
      chk("R7 done_n", done_n, 0);
      chk("R7 result", int'(result), 12'hDB6);
   endtask

   task automatic t_power();
      conv_timed(8'h40, 12'h444);
      chk("R8 internal clock", clk_int, 1);
      vin = 12'h3C3;
      do_write(8'h80);
      step(10);
      chk("R9 standby deferred", stby, 0);
      chk("R8 clk sticky standby", clk_int, 1);
      step(9);
      chk("R9 done", done_n, 0);
      chk("R9 standby entered", stby, 1);
      @(negedge clk);
      wr_n = 1'b0;
      ctrl_byte = 8'h00;
      step(1);
      chk("R9 wake on fall", stby, 0);
      wr_n = 1'b1;
      step(1);
      chk("R8 external clock", clk_int, 0);
      step(18);
      chk("R9 wake conversion done", done_n, 0);
      vin = 12'h0AA;
      do_write(8'hC0);
      step(10);
      chk("R9 full deferred", full_pd, 0);
      step(9);
      chk("R9 full entered", full_pd, 1);
      chk("R9 no standby", stby, 0);
      chk("R8 clk sticky full", clk_int, 0);
      conv_timed(8'h01, 12'h321);
      chk("R9 full cleared", full_pd, 0);
   endtask

   task automatic t_shdn();
      vin = 12'h777;
      do_write(8'h04);
      step(10);
      shdn_n = 1'b0;
      step(1);
      chk("R10 full_pd", full_pd, 1);
      chk("R10 busy aborted", busy, 0);
      chk("R10 track off", track, 0);
      do_write(8'h07);
      step(1);
      chk("R10 write ignored chan", chan_sel, 4);
      chk("R10 write ignored track", track, 0);
      step(25);
      chk("R10 no done", done_n, 1);
      chk("R10 no conv", busy, 0);
      shdn_n = 1'b1;
      step(1);
      chk("R10 released", full_pd, 0);
      conv_timed(8'h06, 12'hE01);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_codes();
      t_read();
      t_host_acq();
      t_abort();
      t_power();
      t_shdn();
      step(2);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule